// File: doc/BRIEF.md
# Paravirtual Device Common Configuration Register File

This block is the device-side register file that a driver uses to bring up a paravirtualized PCI device. It sits behind a simple memory-mapped bus that has separate read and write strobes, four byte enables, a 6-bit byte address and 32-bit data. Through this bus the driver can:

- read the feature words the device offers and write back the features it accepts;
- step the device status byte through its handshake;
- program one bank of ring setup registers per queue.

Feature words and queue registers are reached through select registers rather than through a flat map.

The rest of the device receives the live state on dedicated outputs:

- the accepted driver feature words;
- the status byte;
- each queue's size, its enable, and its descriptor, available and used ring addresses.

The register file guards the rings while they are live. Once a queue is enabled, its size and ring addresses are frozen. Only a status write of zero unfreezes them. That write clears all negotiated state in one cycle and advances the configuration generation counter.

Top module: `pvdev_common_cfg`

## Requirements

- R1: A write with byte enable 0 set to word 0x14 and a nonzero low byte stores that byte as device status. The status reads back unchanged in bits [7:0] of 0x14 and appears on `dev_status_o`. The bit meanings are acknowledge = bit 0, driver = bit 1, driver-ok = bit 2, features-ok = bit 3 and failed = bit 7.
- R2: A status write of zero does all of the following in a single clock cycle:
  - clears the status byte, every driver feature word, every queue enable and every ring address;
  - returns every queue size to `QSIZE_MAX`;
  - increments the 8-bit configuration generation, which reads in bits [15:8] of 0x14.
- R3: Reading 0x04 returns slice number `sel` of `dev_features_i`, that is bits [32*sel+31 : 32*sel], where `sel` is the device feature select register at 0x00. A select of `NUM_FEAT_WORDS` or more reads zero.
- R4: A write to 0x0C goes into the driver feature word named by the driver feature select at 0x08. That word reads back at 0x0C and drives `drv_features_o` at the same slice position. If the select is out of range, the write is ignored and 0x0C reads zero.
- R5: The queue registers at 0x18 to 0x37 refer to the queue named by queue select, which is bits [31:16] of 0x14. A select of `NUM_QUEUES` or more reads zero at every queue register and ignores writes to them.
- R6: Queue size is bits [15:0] of 0x18 and resets to `QSIZE_MAX`. A written size is taken only if the queue is not enabled and the value lies between 1 and `QSIZE_MAX`. Any other size write is ignored.
- R7: Queue enable is bits [15:0] of 0x1C and reads as 1 or 0. Any nonzero value written through the enabled lanes sets it. Writes of zero are ignored. Only R2 clears it.
- R8: While a queue is enabled, writes to its size and to its six ring address words are ignored. Its MSI-X vector stays writable. The ring words are:
  - descriptor low/high at 0x20/0x24;
  - available low/high at 0x28/0x2C;
  - used low/high at 0x30/0x34.
- R9: The config MSI-X vector (bits [15:0] of 0x10) and the queue MSI-X vector (bits [31:16] of 0x18) read back exactly what was written, including 0xFFFF for "no vector". Both reset to 0xFFFF, and R2 does not change them.
- R10: The following read-only fields ignore writes:
  - the number of queues (bits [31:16] of 0x10, reads `NUM_QUEUES`);
  - the configuration generation;
  - the device feature word;
  - the notify offset (bits [31:16] of 0x1C, reads the selected queue index).

  Offsets 0x38 to 0x3F read zero, and `bus_rdata` is zero whenever `bus_rd` is low.
- R11: Only the byte lanes whose byte enable is set are written. An access whose address bits [1:0] are nonzero is dropped: a write has no effect and a read returns zero.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; read data is combinational in the same cycle |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| dev_features_i | input | NUM_FEAT_WORDS*32 | Feature set offered by the device |
| drv_features_o | output | NUM_FEAT_WORDS*32 | Feature words accepted by the driver |
| dev_status_o | output | 8 | Current device status byte |
| q_enable_o | output | NUM_QUEUES | Per-queue enable |
| q_size_o | output | NUM_QUEUES*16 | Per-queue ring size |
| q_desc_o | output | NUM_QUEUES*64 | Per-queue descriptor ring address |
| q_avail_o | output | NUM_QUEUES*64 | Per-queue available ring address |
| q_used_o | output | NUM_QUEUES*64 | Per-queue used ring address |

## Verification

The bench builds the block with its defaults: four queues, two feature words and a maximum queue size of 256. At these values, a queue select of 7 and a feature select of 2 or 9 fall outside the implemented banks, so the out-of-range paths are reachable. A size write of 300 exceeds the cap, which exercises the rejection of oversize values. With several queues present, the bench can show that enabling queue 2 freezes only that queue, while queue 1 stays programmable. It also shows that one zero status write clears all four queues together.

// File: rtl/pvcfg_pkg.sv
package pvcfg_pkg;

  // Word indices (byte address bits [5:2]); the driver relies on these offsets.
  localparam logic [3:0] W_DEV_SEL   = 4'd0;
  localparam logic [3:0] W_DEV_WORD  = 4'd1;
  localparam logic [3:0] W_DRV_SEL   = 4'd2;
  localparam logic [3:0] W_DRV_WORD  = 4'd3;
  localparam logic [3:0] W_MSIX_NQ   = 4'd4;
  localparam logic [3:0] W_STAT      = 4'd5;
  localparam logic [3:0] W_QSIZE     = 4'd6;
  localparam logic [3:0] W_QEN       = 4'd7;
  localparam logic [3:0] W_RING_LO   = 4'd8;
  localparam logic [3:0] W_RING_HI   = 4'd13;

  localparam logic [15:0] NO_VECTOR  = 16'hFFFF;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] m;
    m = lane_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [15:0] half_merge(input logic [15:0] old_v,
                                             input logic [15:0] new_v,
                                             input logic [1:0]  be);
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}};
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/pvcfg_feature_bank.sv
module pvcfg_feature_bank
  import pvcfg_pkg::*;
#(
  parameter int NUM_FEAT_WORDS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic [NUM_FEAT_WORDS*32-1:0] dev_feat_i,
  input  logic                        wr_dev_sel,
  input  logic                        wr_drv_sel,
  input  logic                        wr_drv_word,
  input  logic [3:0]                  be,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 dev_sel_o,
  output logic [31:0]                 drv_sel_o,
  output logic [31:0]                 dev_word_o,
  output logic [31:0]                 drv_word_o,
  output logic [NUM_FEAT_WORDS*32-1:0] drv_feat_o
);

  logic [31:0] dev_sel_q;
  logic [31:0] drv_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_sel_q <= '0;
      drv_sel_q <= '0;
    end else begin
      if (wr_dev_sel) dev_sel_q <= lane_merge(dev_sel_q, wdata, be);
      if (wr_drv_sel) drv_sel_q <= lane_merge(drv_sel_q, wdata, be);
    end
  end

  for (genvar g = 0; g < NUM_FEAT_WORDS; g++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    word_q <= '0;
      else if (clr)                                  word_q <= '0;
      else if (wr_drv_word && drv_sel_q == 32'(g))   word_q <= lane_merge(word_q, wdata, be);
    end
    assign drv_feat_o[g*32 +: 32] = word_q;
  end

  always_comb begin
    dev_word_o = '0;
    drv_word_o = '0;
    for (int i = 0; i < NUM_FEAT_WORDS; i++) begin
      if (dev_sel_q == 32'(i)) dev_word_o = dev_feat_i[i*32 +: 32];
      if (drv_sel_q == 32'(i)) drv_word_o = drv_feat_o[i*32 +: 32];
    end
  end

  assign dev_sel_o = dev_sel_q;
  assign drv_sel_o = drv_sel_q;

endmodule

// File: rtl/pvcfg_queue_slot.sv
module pvcfg_queue_slot
  import pvcfg_pkg::*;
#(
  parameter int QSIZE_MAX = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_hit,
  input  logic [3:0]  word,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [15:0] size_o,
  output logic [15:0] msix_o,
  output logic        en_o,
  output logic [63:0] desc_o,
  output logic [63:0] avail_o,
  output logic [63:0] used_o
);

  localparam logic [15:0] SIZE_CAP = 16'(QSIZE_MAX);
  localparam int          NRING    = 6;

  logic [15:0] size_q;
  logic [15:0] msix_q;
  logic        en_q;
  logic [31:0] ring_q [NRING];

  logic [15:0] size_nxt;
  logic        size_ok;
  logic        msix_wr;
  logic        en_set;
  logic        ring_wr;
  logic [2:0]  ring_idx;

  assign size_nxt = half_merge(size_q, wdata[15:0], be[1:0]);
  assign size_ok  = wr_hit && word == W_QSIZE && |be[1:0] && !en_q
                    && size_nxt != 16'd0 && size_nxt <= SIZE_CAP;
  assign msix_wr  = wr_hit && word == W_QSIZE && |be[3:2];
  assign en_set   = wr_hit && word == W_QEN && |(wdata[15:0] & lane_mask(be)[15:0]);
  assign ring_wr  = wr_hit && word >= W_RING_LO && word <= W_RING_HI && !en_q;
  assign ring_idx = 3'(word - W_RING_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= SIZE_CAP;
      en_q   <= 1'b0;
      for (int i = 0; i < NRING; i++) ring_q[i] <= '0;
    end else if (clr) begin
      size_q <= SIZE_CAP;
      en_q   <= 1'b0;
      for (int i = 0; i < NRING; i++) ring_q[i] <= '0;
    end else begin
      if (size_ok) size_q <= size_nxt;
      if (en_set)  en_q   <= 1'b1;
      if (ring_wr) ring_q[ring_idx] <= lane_merge(ring_q[ring_idx], wdata, be);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       msix_q <= NO_VECTOR;
    else if (msix_wr) msix_q <= half_merge(msix_q, wdata[31:16], be[3:2]);
  end

  assign size_o  = size_q;
  assign msix_o  = msix_q;
  assign en_o    = en_q;
  assign desc_o  = {ring_q[1], ring_q[0]};
  assign avail_o = {ring_q[3], ring_q[2]};
  assign used_o  = {ring_q[5], ring_q[4]};

endmodule

// File: rtl/pvdev_common_cfg.sv
module pvdev_common_cfg
  import pvcfg_pkg::*;
#(
  parameter int NUM_QUEUES     = 4,
  parameter int NUM_FEAT_WORDS = 2,
  parameter int QSIZE_MAX      = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [5:0]                    bus_addr,
  input  logic [3:0]                    bus_be,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_FEAT_WORDS*32-1:0]  dev_features_i,
  output logic [NUM_FEAT_WORDS*32-1:0]  drv_features_o,
  output logic [7:0]                    dev_status_o,
  output logic [NUM_QUEUES-1:0]         q_enable_o,
  output logic [NUM_QUEUES*16-1:0]      q_size_o,
  output logic [NUM_QUEUES*64-1:0]      q_desc_o,
  output logic [NUM_QUEUES*64-1:0]      q_avail_o,
  output logic [NUM_QUEUES*64-1:0]      q_used_o
);

  localparam logic [15:0] QSEL_LIMIT = 16'(NUM_QUEUES);

  // Decoded bus events, named for the checker.
  logic       acc_ok, wr_go, rd_go;
  logic [3:0] word;
  logic       status_wr_evt, status_clr_evt;
  logic       qsel_valid;

  logic [7:0]  status_q;
  logic [7:0]  cfg_gen;
  logic [15:0] qsel_q;
  logic [15:0] cfg_msix_q;

  assign word           = bus_addr[5:2];
  assign acc_ok         = bus_addr[1:0] == 2'b00;
  assign wr_go          = bus_wr && acc_ok;
  assign rd_go          = bus_rd && acc_ok;
  assign status_wr_evt  = wr_go && word == W_STAT && bus_be[0];
  assign status_clr_evt = status_wr_evt && bus_wdata[7:0] == 8'd0;
  assign qsel_valid     = qsel_q < QSEL_LIMIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= '0;
      cfg_gen    <= '0;
      qsel_q     <= '0;
      cfg_msix_q <= NO_VECTOR;
    end else begin
      if (status_wr_evt)  status_q <= bus_wdata[7:0];
      if (status_clr_evt) cfg_gen  <= cfg_gen + 8'd1;
      if (wr_go && word == W_STAT && |bus_be[3:2])
        qsel_q <= half_merge(qsel_q, bus_wdata[31:16], bus_be[3:2]);
      if (wr_go && word == W_MSIX_NQ && |bus_be[1:0])
        cfg_msix_q <= half_merge(cfg_msix_q, bus_wdata[15:0], bus_be[1:0]);
    end
  end

  // Feature words
  logic [31:0] dev_sel, drv_sel, dev_word, drv_word;

  pvcfg_feature_bank #(.NUM_FEAT_WORDS(NUM_FEAT_WORDS)) u_feat (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (status_clr_evt),
    .dev_feat_i (dev_features_i),
    .wr_dev_sel (wr_go && word == W_DEV_SEL),
    .wr_drv_sel (wr_go && word == W_DRV_SEL),
    .wr_drv_word(wr_go && word == W_DRV_WORD),
    .be         (bus_be),
    .wdata      (bus_wdata),
    .dev_sel_o  (dev_sel),
    .drv_sel_o  (drv_sel),
    .dev_word_o (dev_word),
    .drv_word_o (drv_word),
    .drv_feat_o (drv_features_o)
  );

  // Queue slots
  logic [15:0] s_size [NUM_QUEUES];
  logic [15:0] s_msix [NUM_QUEUES];
  logic [63:0] s_desc [NUM_QUEUES];
  logic [63:0] s_avail[NUM_QUEUES];
  logic [63:0] s_used [NUM_QUEUES];

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_q
    pvcfg_queue_slot #(.QSIZE_MAX(QSIZE_MAX)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (status_clr_evt),
      .wr_hit (wr_go && qsel_valid && qsel_q == 16'(g)),
      .word   (word),
      .be     (bus_be),
      .wdata  (bus_wdata),
      .size_o (s_size[g]),
      .msix_o (s_msix[g]),
      .en_o   (q_enable_o[g]),
      .desc_o (s_desc[g]),
      .avail_o(s_avail[g]),
      .used_o (s_used[g])
    );
    assign q_size_o [g*16 +: 16] = s_size[g];
    assign q_desc_o [g*64 +: 64] = s_desc[g];
    assign q_avail_o[g*64 +: 64] = s_avail[g];
    assign q_used_o [g*64 +: 64] = s_used[g];
  end

  // Selected queue view
  logic [15:0] sel_size, sel_msix;
  logic        sel_en;
  logic [63:0] sel_desc, sel_avail, sel_used;

  always_comb begin
    sel_size  = '0;
    sel_msix  = '0;
    sel_en    = 1'b0;
    sel_desc  = '0;
    sel_avail = '0;
    sel_used  = '0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      if (qsel_q == 16'(i)) begin
        sel_size  = s_size[i];
        sel_msix  = s_msix[i];
        sel_en    = q_enable_o[i];
        sel_desc  = s_desc[i];
        sel_avail = s_avail[i];
        sel_used  = s_used[i];
      end
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      unique case (word)
        W_DEV_SEL:  bus_rdata = dev_sel;
        W_DEV_WORD: bus_rdata = dev_word;
        W_DRV_SEL:  bus_rdata = drv_sel;
        W_DRV_WORD: bus_rdata = drv_word;
        W_MSIX_NQ:  bus_rdata = {QSEL_LIMIT, cfg_msix_q};
        W_STAT:     bus_rdata = {qsel_q, cfg_gen, status_q};
        W_QSIZE:    bus_rdata = qsel_valid ? {sel_msix, sel_size} : '0;
        W_QEN:      bus_rdata = qsel_valid ? {qsel_q, 15'd0, sel_en} : '0;
        4'd8:       bus_rdata = qsel_valid ? sel_desc[31:0]   : '0;
        4'd9:       bus_rdata = qsel_valid ? sel_desc[63:32]  : '0;
        4'd10:      bus_rdata = qsel_valid ? sel_avail[31:0]  : '0;
        4'd11:      bus_rdata = qsel_valid ? sel_avail[63:32] : '0;
        4'd12:      bus_rdata = qsel_valid ? sel_used[31:0]   : '0;
        4'd13:      bus_rdata = qsel_valid ? sel_used[63:32]  : '0;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign dev_status_o = status_q;

endmodule

// File: rtl/pvdev_common_cfg_chk.sv
module pvdev_common_cfg_chk #(
  parameter int NUM_QUEUES     = 4,
  parameter int NUM_FEAT_WORDS = 2,
  parameter int QSIZE_MAX      = 256
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_rd,
  input logic [31:0]                  bus_rdata,
  input logic                         status_wr_evt,
  input logic                         status_clr_evt,
  input logic [7:0]                   status_wdata,
  input logic [7:0]                   cfg_gen,
  input logic [7:0]                   dev_status_o,
  input logic [NUM_FEAT_WORDS*32-1:0] drv_features_o,
  input logic [NUM_QUEUES-1:0]        q_enable_o,
  input logic [NUM_QUEUES*16-1:0]     q_size_o,
  input logic [NUM_QUEUES*64-1:0]     q_desc_o,
  input logic [NUM_QUEUES*64-1:0]     q_avail_o,
  input logic [NUM_QUEUES*64-1:0]     q_used_o
);

  AST_STATUS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr_evt |=> dev_status_o == $past(status_wdata)); // R1

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr_evt |=> (q_enable_o == '0 && drv_features_o == '0 && dev_status_o == 8'd0)); // R2

  AST_GEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr_evt |=> cfg_gen == $past(cfg_gen) + 8'd1); // R2

  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !status_clr_evt |=> $stable(cfg_gen)); // R10

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !status_clr_evt |=> (q_enable_o & $past(q_enable_o)) == $past(q_enable_o)); // R7

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 32'd0); // R10

  for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_q
    AST_RING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (q_enable_o[i] && !status_clr_evt) |=>
        ($stable(q_desc_o[i*64 +: 64]) && $stable(q_avail_o[i*64 +: 64])
         && $stable(q_used_o[i*64 +: 64]) && $stable(q_size_o[i*16 +: 16]))); // R8

    AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      q_size_o[i*16 +: 16] != 16'd0 && q_size_o[i*16 +: 16] <= 16'(QSIZE_MAX)); // R6
  end

endmodule

bind pvdev_common_cfg pvdev_common_cfg_chk #(
  .NUM_QUEUES    (NUM_QUEUES),
  .NUM_FEAT_WORDS(NUM_FEAT_WORDS),
  .QSIZE_MAX     (QSIZE_MAX)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_rd        (bus_rd),
  .bus_rdata     (bus_rdata),
  .status_wr_evt (status_wr_evt),
  .status_clr_evt(status_clr_evt),
  .status_wdata  (bus_wdata[7:0]),
  .cfg_gen       (cfg_gen),
  .dev_status_o  (dev_status_o),
  .drv_features_o(drv_features_o),
  .q_enable_o    (q_enable_o),
  .q_size_o      (q_size_o),
  .q_desc_o      (q_desc_o),
  .q_avail_o     (q_avail_o),
  .q_used_o      (q_used_o)
);

// File: tb/pvdev_common_cfg_tb.sv
module pvdev_common_cfg_tb;

  localparam int NQ   = 4;
  localparam int NFW  = 2;
  localparam int QMAX = 256;
  localparam logic [NFW*32-1:0] DEV_FEAT = 64'h1357_9BDF_8000_0021;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NFW*32-1:0] drv_features_o;
  logic [7:0] dev_status_o;
  logic [NQ-1:0] q_enable_o;
  logic [NQ*16-1:0] q_size_o;
  logic [NQ*64-1:0] q_desc_o, q_avail_o, q_used_o;

  always #4 clk = ~clk; // 125 MHz

  pvdev_common_cfg #(.NUM_QUEUES(NQ), .NUM_FEAT_WORDS(NFW), .QSIZE_MAX(QMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_features_i(DEV_FEAT), .drv_features_o(drv_features_o),
    .dev_status_o(dev_status_o), .q_enable_o(q_enable_o), .q_size_o(q_size_o),
    .q_desc_o(q_desc_o), .q_avail_o(q_avail_o), .q_used_o(q_used_o)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit [31:0] m_dfsel, m_drsel;
  bit [31:0] m_drf [NFW];
  bit [15:0] m_cfgmsix, m_qsel;
  bit [7:0]  m_status, m_gen;
  bit [15:0] m_qsize [NQ];
  bit [15:0] m_qmsix [NQ];
  bit        m_qen [NQ];
  bit [31:0] m_ring [NQ][6];

  function automatic bit [31:0] bmerge(bit [31:0] o, bit [31:0] n, bit [3:0] be);
    bit [31:0] r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  task automatic m_clear();
    m_status = 0;
    for (int i = 0; i < NFW; i++) m_drf[i] = 0;
    for (int q = 0; q < NQ; q++) begin
      m_qen[q] = 0;
      m_qsize[q] = 16'(QMAX);
      for (int w = 0; w < 6; w++) m_ring[q][w] = 0;
    end
  endtask

  task automatic m_init();
    m_clear();
    m_dfsel = 0; m_drsel = 0; m_cfgmsix = 16'hFFFF; m_qsel = 0; m_gen = 0;
    for (int q = 0; q < NQ; q++) m_qmsix[q] = 16'hFFFF;
  endtask

  task automatic m_write(bit [5:0] a, bit [3:0] be, bit [31:0] d);
    int w, q;
    bit ok;
    bit [31:0] t;
    if (a[1:0] != 0) return;
    w = int'(a[5:2]);
    q = int'(m_qsel);
    ok = m_qsel < NQ;
    case (w)
      0: m_dfsel = bmerge(m_dfsel, d, be);
      2: m_drsel = bmerge(m_drsel, d, be);
      3: if (m_drsel < NFW) m_drf[m_drsel] = bmerge(m_drf[m_drsel], d, be);
      4: begin t = bmerge({16'h0, m_cfgmsix}, d, be & 4'b0011); m_cfgmsix = t[15:0]; end
      5: begin
        if (be[0]) begin
          if (d[7:0] == 0) begin m_clear(); m_gen = m_gen + 1; end
          else m_status = d[7:0];
        end
        t = bmerge({m_qsel, 16'h0}, d, be & 4'b1100);
        m_qsel = t[31:16];
      end
      6: if (ok) begin
        t = bmerge({m_qmsix[q], m_qsize[q]}, d, be);
        if (be[1:0] != 0 && !m_qen[q] && t[15:0] != 0 && t[15:0] <= QMAX) m_qsize[q] = t[15:0];
        m_qmsix[q] = t[31:16];
      end
      7: if (ok) begin
        t = bmerge(32'h0, d, be & 4'b0011);
        if (t != 0) m_qen[q] = 1;
      end
      8, 9, 10, 11, 12, 13: if (ok && !m_qen[q]) m_ring[q][w-8] = bmerge(m_ring[q][w-8], d, be);
      default: ;
    endcase
  endtask

  function automatic bit [31:0] m_read(bit [5:0] a);
    int w, q;
    bit ok;
    if (a[1:0] != 0) return 0;
    w = int'(a[5:2]);
    q = int'(m_qsel);
    ok = m_qsel < NQ;
    case (w)
      0: return m_dfsel;
      1: return (m_dfsel < NFW) ? DEV_FEAT[m_dfsel*32 +: 32] : 32'h0;
      2: return m_drsel;
      3: return (m_drsel < NFW) ? m_drf[m_drsel] : 32'h0;
      4: return {16'(NQ), m_cfgmsix};
      5: return {m_qsel, m_gen, m_status};
      6: return ok ? {m_qmsix[q], m_qsize[q]} : 32'h0;
      7: return ok ? {m_qsel, 15'h0, m_qen[q]} : 32'h0;
      8, 9, 10, 11, 12, 13: return ok ? m_ring[q][w-8] : 32'h0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_init();
    else if (bus_wr) m_write(bus_addr, bus_be, bus_wdata);
  end

  // Per-cycle comparison of exported state
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 dev_status_o", {24'h0, dev_status_o}, {24'h0, m_status});
      chk("R10 rdata idle", bus_rdata, 32'h0);
      for (int i = 0; i < NFW; i++) chk("R4 drv_features_o", drv_features_o[i*32 +: 32], m_drf[i]);
      for (int q = 0; q < NQ; q++) begin
        chk("R7 q_enable_o", {31'h0, q_enable_o[q]}, {31'h0, m_qen[q]});
        chk("R6 q_size_o", {16'h0, q_size_o[q*16 +: 16]}, {16'h0, m_qsize[q]});
        chk("R8 q_desc_o lo", q_desc_o[q*64 +: 32], m_ring[q][0]);
        chk("R8 q_desc_o hi", q_desc_o[q*64+32 +: 32], m_ring[q][1]);
        chk("R8 q_avail_o lo", q_avail_o[q*64 +: 32], m_ring[q][2]);
        chk("R8 q_avail_o hi", q_avail_o[q*64+32 +: 32], m_ring[q][3]);
        chk("R8 q_used_o lo", q_used_o[q*64 +: 32], m_ring[q][4]);
        chk("R8 q_used_o hi", q_used_o[q*64+32 +: 32], m_ring[q][5]);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    #1;
    chk(tag, bus_rdata, m_read(a));
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    rd(6'h14, "R1 reset status/gen/qsel");
    rd(6'h10, "R9 reset msix, R10 queue count");
    rd(6'h18, "R6 reset size");
    rd(6'h1C, "R10 notify q0");

    // Device feature window
    wr(6'h00, 4'hF, 0);  rd(6'h04, "R3 device word 0");
    wr(6'h00, 4'hF, 1);  rd(6'h04, "R3 device word 1");
    wr(6'h00, 4'hF, 2);  rd(6'h04, "R3 out of range");

    // Driver feature window and byte lanes
    wr(6'h08, 4'hF, 1);
    wr(6'h0C, 4'b0011, 32'hDEAD_BEEF); rd(6'h0C, "R11 low lanes");
    wr(6'h0C, 4'b1100, 32'hCAFE_0000); rd(6'h0C, "R11 high lanes");
    wr(6'h08, 4'hF, 0);
    wr(6'h0C, 4'hF, 32'h0000_0003);    rd(6'h0C, "R4 word 0");
    wr(6'h08, 4'hF, 9);
    wr(6'h0C, 4'hF, 32'hFFFF_FFFF);    rd(6'h0C, "R4 out of range");

    // Status handshake
    wr(6'h14, 4'b0001, 32'h01); rd(6'h14, "R1 ack");
    wr(6'h14, 4'b0001, 32'h03); rd(6'h14, "R1 driver");
    wr(6'h14, 4'b0001, 32'h0B); rd(6'h14, "R1 features ok");
    wr(6'h14, 4'b0001, 32'h0F); rd(6'h14, "R1 driver ok");
    wr(6'h14, 4'b0001, 32'h8F); rd(6'h14, "R1 failed bit");

    // Config vector
    wr(6'h10, 4'b0011, 32'h0000_0012); rd(6'h10, "R9 cfg vector");
    wr(6'h10, 4'b0011, 32'h0000_FFFF); rd(6'h10, "R9 cfg no vector");

    // Queue 2 setup
    wr(6'h14, 4'b1100, 32'h0002_0000);  rd(6'h18, "R5 select q2");
    wr(6'h18, 4'b0011, 300);            rd(6'h18, "R6 above max");
    wr(6'h18, 4'b0011, 0);              rd(6'h18, "R6 zero size");
    wr(6'h18, 4'hF, 32'hFFFF_0080);     rd(6'h18, "R6 R9 size and vector");
    for (int w = 0; w < 6; w++) wr(6'(6'h20 + 4*w), 4'hF, 32'h1000_0000 + 32'(w) * 32'h111);
    for (int w = 0; w < 6; w++) rd(6'(6'h20 + 4*w), "R5 ring readback");
    wr(6'h1C, 4'b0011, 0);              rd(6'h1C, "R7 zero ignored");
    wr(6'h1C, 4'b0010, 32'h0000_0100);  rd(6'h1C, "R7 enable set");
    wr(6'h18, 4'b0011, 64);             rd(6'h18, "R8 size frozen");
    wr(6'h20, 4'hF, 32'h0000_FFFF);     rd(6'h20, "R8 ring frozen");
    wr(6'h18, 4'b1100, 32'h0005_0000);  rd(6'h18, "R8 vector writable");
    wr(6'h1C, 4'b0011, 0);              rd(6'h1C, "R7 sticky");

    // Queue 1 unaffected
    wr(6'h14, 4'b1100, 32'h0001_0000);
    rd(6'h1C, "R5 q1 enable");
    wr(6'h18, 4'b0011, 32);             rd(6'h18, "R5 q1 size");

    // Out-of-range queue select
    wr(6'h14, 4'b1100, 32'h0007_0000);
    wr(6'h18, 4'hF, 32'h0003_0010);
    wr(6'h1C, 4'hF, 1);
    wr(6'h24, 4'hF, 5);
    rd(6'h18, "R5 oor size");
    rd(6'h1C, "R5 oor enable");
    rd(6'h24, "R5 oor ring");

    // Read-only fields and unmapped space
    wr(6'h00, 4'hF, 1);
    wr(6'h04, 4'hF, 32'h0);             rd(6'h04, "R10 device word ro");
    wr(6'h10, 4'b1100, 32'h00AA_0000);  rd(6'h10, "R10 queue count ro");
    wr(6'h14, 4'b0010, 32'h0000_5500);  rd(6'h14, "R10 generation ro");
    wr(6'h14, 4'b1100, 32'h0002_0000);
    wr(6'h1C, 4'b1100, 32'h1234_0000);  rd(6'h1C, "R10 notify ro");
    rd(6'h38, "R10 unmapped 0x38");
    rd(6'h3C, "R10 unmapped 0x3C");

    // Misaligned access dropped
    wr(6'h15, 4'hF, 32'h0);             rd(6'h14, "R11 misaligned write");
    rd(6'h16, "R11 misaligned read");

    // Status reset
    wr(6'h14, 4'b0001, 32'h0);          rd(6'h14, "R2 status and generation");
    rd(6'h1C, "R2 enable cleared");
    rd(6'h18, "R2 size restored, R9 vector kept");
    rd(6'h20, "R2 ring cleared");
    wr(6'h08, 4'hF, 1);                 rd(6'h0C, "R2 driver word cleared");
    wr(6'h28, 4'hF, 32'h0000_ABCD);     rd(6'h28, "R2 ring writable again");
    wr(6'h14, 4'b0001, 32'h0);          rd(6'h14, "R2 second generation step");

    repeat (2) @(posedge clk);
    summary();
  end

endmodule